// File: doc/BRIEF.md
# Reset Controller with Cause Capture

This block gathers reset requests from every source a small chip has and turns each accepted one into a system reset pulse of fixed length. The sources are an external pin, a power-on detector, a brown-out detector, a watchdog, a debugger, a core system-reset request and two keyed software writes. The detectors and the watchdog timer are outside the block and appear only as request inputs. The block stores a sticky bit for each source in a status register, so that firmware running after the reset can tell why it happened.

Software reaches the block over a plain 32-bit register bus: address, write strobe, write data and registered read data. Besides the reset path, the block has a brown-out interrupt with enable, status, set and clear locations, and a static reset level for a trace port. All state lives in one always-on register set. The synchronous input `rst` brings that set to its idle state.

Top module: `rstctl_top`

## Requirements
- R1: After `rst`, `sys_rst`, `trace_rst` and `bod_irq` are 0 and every readable location returns 0.
- R2: An accepted request drives `sys_rst` high from the clock edge that samples it, for exactly 16 cycles, and then drives it low. External, debugger, power-on and core system-reset requests are always accepted.
- R3: Writing a value whose low byte is 0x1B to offset 0x004 starts a warm software reset. Any other low byte at that offset has no effect.
- R4: Writing a value whose low byte is 0xD4 to offset 0x008 starts a cold software reset. Any other low byte at that offset has no effect.
- R5: Offset 0x000 holds the brown-out reset enable in bit 0 and the watchdog reset enable in bit 1. A brown-out or watchdog request starts a reset and sets its cause bit only while its enable bit is 1.
- R6: The cause register at offset 0x00C accumulates bits: bit 0 external, bit 1 power-on, bit 2 brown-out, bit 3 cold software reset or core request, bit 4 warm software reset, bit 5 debugger, bit 6 watchdog. These bits survive the reset they cause.
- R7: Writing 1 in bit 0 of offset 0x010 clears all cause bits at once. Writing 0 there has no effect.
- R8: A power-on request leaves only bit 1 set in the cause register.
- R9: Bit 0 of offset 0x014 drives `trace_rst` as a static level and reads back.
- R10: The brown-out interrupt uses bit 0 of enable 0x200, status 0x204, clear 0x208 and set 0x20C. A brown-out request sets the status even when the brown-out reset is disabled. Writing 1 to clear or set changes the status. `bod_irq` is status AND enable.
- R11: A power-on request or a cold software reset clears the configuration, the interrupt enable and the trace reset. A warm software reset keeps them.
- R12: The key, clear-cause, interrupt-clear and interrupt-set locations and unmapped addresses read as 0. Unused upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the register set |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented in the previous cycle |
| ext_req | input | 1 | External reset pin request |
| por_req | input | 1 | Power-on detector request |
| bod_req | input | 1 | Brown-out detector request |
| wdt_req | input | 1 | Watchdog reset request |
| dbg_req | input | 1 | Debugger reset request |
| sysreq_req | input | 1 | Core system-reset request |
| sys_rst | output | 1 | System reset pulse |
| trace_rst | output | 1 | Static trace-port reset |
| bod_irq | output | 1 | Brown-out interrupt |

## Verification
A wrong pulse counter shows as a `sys_rst` width other than 16. This is visible within 17 cycles of the request. A corrupted cause bit, or a clear that misses a bit, appears in the next read of offset 0x00C, one cycle after the address is presented. A missed configuration clear on a cold reset, or an unwanted clear on a warm reset, shows in the next read of 0x000 and 0x200 and at once on `trace_rst`. A wrong interrupt status or enable moves `bod_irq` on the edge of the offending write.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;

  localparam int OFF_CFG     = 'h000;
  localparam int OFF_WARMKEY = 'h004;
  localparam int OFF_COLDKEY = 'h008;
  localparam int OFF_CAUSE   = 'h00C;
  localparam int OFF_CLRC    = 'h010;
  localparam int OFF_TRACE   = 'h014;
  localparam int OFF_IEN     = 'h200;
  localparam int OFF_IST     = 'h204;
  localparam int OFF_ICLR    = 'h208;
  localparam int OFF_ISET    = 'h20C;

  localparam int         KEY_W    = 8;
  localparam logic [7:0] WARM_KEY = 8'h1B;
  localparam logic [7:0] COLD_KEY = 8'hD4;

  // bit 0 is external, bit 6 is watchdog
  typedef struct packed {
    logic wdt;
    logic dbg;
    logic warm;
    logic cold;
    logic bod;
    logic pwr;
    logic ext;
  } cause_t;

  localparam int CAUSE_W = $bits(cause_t);

  typedef struct packed {
    logic cfg;
    logic warm_ok;
    logic cold_ok;
    logic clr_cause;
    logic trace;
    logic ien;
    logic iclr;
    logic iset;
  } wstb_t;

endpackage

// File: rtl/rstctl_decode.sv
module rstctl_decode
  import rstctl_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output wstb_t             wstb
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  logic [KEY_W-1:0] key_byte;
  assign key_byte = wdata[KEY_W-1:0];

  always_comb begin
    wstb           = '0;
    wstb.cfg       = we && hit(addr, OFF_CFG);
    wstb.warm_ok   = we && hit(addr, OFF_WARMKEY) && (key_byte == WARM_KEY);
    wstb.cold_ok   = we && hit(addr, OFF_COLDKEY) && (key_byte == COLD_KEY);
    wstb.clr_cause = we && hit(addr, OFF_CLRC) && wdata[0];
    wstb.trace     = we && hit(addr, OFF_TRACE);
    wstb.ien       = we && hit(addr, OFF_IEN);
    wstb.iclr      = we && hit(addr, OFF_ICLR) && wdata[0];
    wstb.iset      = we && hit(addr, OFF_ISET) && wdata[0];
  end

endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause
  import rstctl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   ext_req,
  input  logic   por_req,
  input  logic   bod_req,
  input  logic   wdt_req,
  input  logic   dbg_req,
  input  logic   sysreq_req,
  input  logic   warm_ok,
  input  logic   cold_ok,
  input  logic   bod_en,
  input  logic   wdt_en,
  input  logic   clr_cause,
  output cause_t cause,
  output logic   accept,
  output logic   cold_class
);

  cause_t hits;
  cause_t cause_q;

  always_comb begin
    hits      = '0;
    hits.ext  = ext_req;
    hits.pwr  = por_req;
    hits.bod  = bod_req && bod_en;
    hits.cold = cold_ok || sysreq_req;
    hits.warm = warm_ok;
    hits.dbg  = dbg_req;
    hits.wdt  = wdt_req && wdt_en;
  end

  assign accept     = |hits;
  assign cold_class = por_req || cold_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
    end else if (por_req) begin
      cause_q     <= '0;
      cause_q.pwr <= 1'b1;
    end else if (clr_cause) begin
      cause_q <= hits;
    end else begin
      cause_q <= cause_q | hits;
    end
  end

  assign cause = cause_q;

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_cause && !accept) |=> (cause == '0));

  assert_poweron_R8: assert property (@(posedge clk) disable iff (rst)
    por_req |=> (cause == cause_t'(CAUSE_W'(2))));

  assert_wdt_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (wdt_req && !wdt_en && !clr_cause && !por_req) |=> (cause.wdt == $past(cause.wdt)));

endmodule

// File: rtl/rstctl_regs.sv
module rstctl_regs
  import rstctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  wstb_t wstb,
  input  logic  wbit0,
  input  logic  wbit1,
  input  logic  cold_class,
  input  logic  bod_evt,
  output logic  bod_en,
  output logic  wdt_en,
  output logic  int_en,
  output logic  int_st,
  output logic  trace_rst,
  output logic  bod_irq
);

  logic bod_en_q, wdt_en_q, int_en_q, int_st_q, trace_q, irq_q;
  logic en_nx, st_nx;

  always_comb begin
    en_nx = int_en_q;
    if (cold_class)    en_nx = 1'b0;
    else if (wstb.ien) en_nx = wbit0;
    st_nx = int_st_q;
    if (wstb.iclr) st_nx = 1'b0;
    if (wstb.iset || bod_evt) st_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bod_en_q <= 1'b0;
      wdt_en_q <= 1'b0;
      trace_q  <= 1'b0;
      int_en_q <= 1'b0;
      int_st_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (cold_class) begin
        bod_en_q <= 1'b0;
        wdt_en_q <= 1'b0;
        trace_q  <= 1'b0;
      end else begin
        if (wstb.cfg) begin
          bod_en_q <= wbit0;
          wdt_en_q <= wbit1;
        end
        if (wstb.trace) trace_q <= wbit0;
      end
      int_en_q <= en_nx;
      int_st_q <= st_nx;
      irq_q    <= en_nx && st_nx;
    end
  end

  assign bod_en    = bod_en_q;
  assign wdt_en    = wdt_en_q;
  assign int_en    = int_en_q;
  assign int_st    = int_st_q;
  assign trace_rst = trace_q;
  assign bod_irq   = irq_q;

  assert_intset_R10: assert property (@(posedge clk) disable iff (rst)
    wstb.iset |=> int_st);

  assert_cold_clear_R11: assert property (@(posedge clk) disable iff (rst)
    cold_class |=> (!bod_en && !wdt_en && !int_en && !trace_rst));

endmodule

// File: rtl/rstctl_pulse.sv
module rstctl_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic sys_rst
);

  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic             out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      out_q <= 1'b0;
    end else begin
      out_q <= start || (cnt > CNT_W'(1));
      if (start)            cnt <= CNT_W'(PULSE_LEN);
      else if (cnt != '0)   cnt <= cnt - CNT_W'(1);
    end
  end

  assign sys_rst = out_q;

  assert_pulse_start_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> sys_rst);

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(PULSE_LEN));

  assert_release_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sys_rst) |-> (cnt == '0));

endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_req,
  input  logic              por_req,
  input  logic              bod_req,
  input  logic              wdt_req,
  input  logic              dbg_req,
  input  logic              sysreq_req,
  output logic              sys_rst,
  output logic              trace_rst,
  output logic              bod_irq
);

  wstb_t  wstb;
  cause_t cause;
  logic   accept, cold_class;
  logic   bod_en, wdt_en, int_en, int_st;
  logic [DATA_W-1:0] rd_nx, rd_q;

  rstctl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .wstb(wstb)
  );

  rstctl_cause u_cause (
    .clk(clk), .rst(rst),
    .ext_req(ext_req), .por_req(por_req), .bod_req(bod_req),
    .wdt_req(wdt_req), .dbg_req(dbg_req), .sysreq_req(sysreq_req),
    .warm_ok(wstb.warm_ok), .cold_ok(wstb.cold_ok),
    .bod_en(bod_en), .wdt_en(wdt_en), .clr_cause(wstb.clr_cause),
    .cause(cause), .accept(accept), .cold_class(cold_class)
  );

  rstctl_regs u_regs (
    .clk(clk), .rst(rst), .wstb(wstb),
    .wbit0(bus_wdata[0]), .wbit1(bus_wdata[1]),
    .cold_class(cold_class), .bod_evt(bod_req),
    .bod_en(bod_en), .wdt_en(wdt_en), .int_en(int_en), .int_st(int_st),
    .trace_rst(trace_rst), .bod_irq(bod_irq)
  );

  rstctl_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst(rst), .start(accept), .sys_rst(sys_rst)
  );

  always_comb begin
    rd_nx = '0;
    if (bus_addr == ADDR_W'(OFF_CFG))   rd_nx = DATA_W'({wdt_en, bod_en});
    if (bus_addr == ADDR_W'(OFF_CAUSE)) rd_nx = DATA_W'(cause);
    if (bus_addr == ADDR_W'(OFF_TRACE)) rd_nx = DATA_W'(trace_rst);
    if (bus_addr == ADDR_W'(OFF_IEN))   rd_nx = DATA_W'(int_en);
    if (bus_addr == ADDR_W'(OFF_IST))   rd_nx = DATA_W'(int_st);
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nx;
  end

  assign bus_rdata = rd_q;

  assert_rdata_upper_R12: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[DATA_W-1:CAUSE_W] == '0);

endmodule

// File: tb/rstctl_top_tb_top.sv
module rstctl_top_tb_top;

  localparam int A_CFG = 'h000, A_WARM = 'h004, A_COLD = 'h008, A_CAUSE = 'h00C,
                 A_CLR = 'h010, A_TRC = 'h014, A_IEN = 'h200, A_IST = 'h204,
                 A_ICLR = 'h208, A_ISET = 'h20C;

  logic        clk = 0;
  logic        rst = 1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ext_req = 0, por_req = 0, bod_req = 0, wdt_req = 0, dbg_req = 0, sysreq_req = 0;
  logic sys_rst, trace_rst, bod_irq;
  logic rd_fire = 0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  rstctl_top dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_req(ext_req), .por_req(por_req), .bod_req(bod_req),
    .wdt_req(wdt_req), .dbg_req(dbg_req), .sysreq_req(sysreq_req),
    .sys_rst(sys_rst), .trace_rst(trace_rst), .bod_irq(bod_irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always @(posedge clk) begin
    if (rd_fire) begin
      #1;
      if (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(a); bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0; bus_wdata = '0;
  endtask

  task automatic bus_read(input int a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = 12'(a); rd_fire = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_fire = 0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ext_req = 1; 1: por_req = 1; 2: bod_req = 1;
      3: wdt_req = 1; 4: dbg_req = 1; default: sysreq_req = 1;
    endcase
    @(negedge clk);
    ext_req = 0; por_req = 0; bod_req = 0; wdt_req = 0; dbg_req = 0; sysreq_req = 0;
  endtask

  task automatic measure(input string tag);
    int n = 0;
    while (sys_rst && n < 100) begin
      n++;
      @(negedge clk);
    end
    check(32'(n), 32'd16, tag);
  endtask

  task automatic quiet(input string tag);
    int hi = 0;
    for (int i = 0; i < 4; i++) begin
      if (sys_rst) hi++;
      @(negedge clk);
    end
    check(32'(hi), 32'd0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check({29'd0, sys_rst, trace_rst, bod_irq}, 32'd0, "R1 outputs idle");
    bus_read(A_CFG, 0, "R1 cfg");
    bus_read(A_CAUSE, 0, "R1 cause");
    bus_read(A_IEN, 0, "R1 ien");
    bus_read(A_IST, 0, "R1 ist");
    bus_read(A_TRC, 0, "R1 trace");

    // R2, R6 external and debugger
    pulse(0); measure("R2 ext width");
    bus_read(A_CAUSE, 32'h01, "R6 ext bit0");
    pulse(4); measure("R2 dbg width");
    bus_read(A_CAUSE, 32'h21, "R6 dbg bit5 accumulates");

    // R7 clear
    bus_write(A_CLR, 0);
    bus_read(A_CAUSE, 32'h21, "R7 zero write ignored");
    bus_write(A_CLR, 1);
    bus_read(A_CAUSE, 0, "R7 clear all");

    // R3 warm key
    bus_write(A_WARM, 32'h1C); quiet("R3 wrong key no pulse");
    bus_read(A_CAUSE, 0, "R3 wrong key no cause");
    bus_write(A_WARM, 32'h1B); measure("R3 warm width");
    bus_read(A_CAUSE, 32'h10, "R3 warm bit4");

    // R5 gating
    pulse(3); quiet("R5 wdt gated");
    bus_read(A_CAUSE, 32'h10, "R5 wdt gated cause");
    pulse(2); quiet("R5 bod gated");
    bus_write(A_CFG, 3);
    pulse(3); measure("R5 wdt enabled width");
    bus_read(A_CAUSE, 32'h50, "R5 wdt bit6");
    pulse(2); measure("R5 bod enabled width");
    bus_read(A_CAUSE, 32'h54, "R5 bod bit2");
    pulse(5); measure("R2 sysreq width");
    bus_read(A_CAUSE, 32'h5C, "R6 sysreq bit3");

    // R11 warm keeps config
    bus_write(A_IEN, 1);
    bus_write(A_TRC, 1);
    bus_write(A_WARM, 32'h1B); measure("R11 warm width");
    bus_read(A_CFG, 3, "R11 warm keeps cfg");
    bus_read(A_IEN, 1, "R11 warm keeps ien");
    check(32'(trace_rst), 1, "R11 warm keeps trace");

    // R4 cold key
    bus_write(A_COLD, 32'hD5); quiet("R4 wrong key no pulse");
    bus_read(A_CFG, 3, "R4 wrong key keeps cfg");
    bus_write(A_CLR, 1);
    bus_write(A_COLD, 32'hD4); measure("R4 cold width");
    bus_read(A_CAUSE, 32'h08, "R4 cold bit3");
    bus_read(A_CFG, 0, "R11 cold clears cfg");
    bus_read(A_IEN, 0, "R11 cold clears ien");
    check(32'(trace_rst), 0, "R11 cold clears trace");

    // R8 power-on
    bus_write(A_CFG, 3);
    pulse(0); measure("R2 ext width again");
    pulse(1); measure("R8 por width");
    bus_read(A_CAUSE, 32'h02, "R8 only bit1");
    bus_read(A_CFG, 0, "R11 por clears cfg");

    // R10 interrupt
    bus_read(A_IST, 1, "R10 status from earlier brown-out");
    bus_write(A_ICLR, 1);
    bus_read(A_IST, 0, "R10 clear");
    pulse(2); quiet("R10 bod no reset when disabled");
    bus_read(A_IST, 1, "R10 bod sets status");
    bus_read(A_CAUSE, 32'h02, "R10 no bod cause when disabled");
    check(32'(bod_irq), 0, "R10 irq masked");
    bus_write(A_IEN, 1);
    check(32'(bod_irq), 1, "R10 irq enabled");
    bus_write(A_ICLR, 1);
    check(32'(bod_irq), 0, "R10 irq cleared");
    bus_write(A_ISET, 1);
    check(32'(bod_irq), 1, "R10 irq set");
    bus_read(A_IST, 1, "R10 set status");

    // R9 trace
    bus_write(A_TRC, 1);
    check(32'(trace_rst), 1, "R9 trace asserted");
    bus_read(A_TRC, 1, "R9 trace readback");
    bus_write(A_TRC, 0);
    check(32'(trace_rst), 0, "R9 trace released");

    // R12 readback
    bus_write(A_CFG, 32'hFFFF_FFFC);
    bus_read(A_CFG, 0, "R12 cfg upper bits");
    bus_read(A_WARM, 0, "R12 warm key reads 0");
    bus_read(A_COLD, 0, "R12 cold key reads 0");
    bus_read(A_CLR, 0, "R12 clear reads 0");
    bus_read(A_ICLR, 0, "R12 iclr reads 0");
    bus_read(A_ISET, 0, "R12 iset reads 0");
    bus_read('h300, 0, "R12 unmapped reads 0");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule